// File: doc/BRIEF.md
# Plane Viewport and Line Address Generator

This block turns the loaded configuration of one graphics plane into two things the rest of the plane pipeline needs while the raster is scanned: a flag saying whether the current screen position lies inside the plane's window, and the byte address where each window line's pixels start in memory. The display timing supplies the running pixel and line counters (one pixel per clock), the field parity and the scan mode. The configuration supplies the window start and end corners, the source size, the address of the first visible source pixel and the line pitch.

Corners are inclusive and packed with the line number in the upper half of each word and the pixel number in the lower half. The plane never scales. If the requested window is larger than the source, its end is pulled in so that the window is exactly as large as the source. If the window is smaller, the source is cropped. Each window line starts with a one-clock request strobe carrying the line's start address, one clock before the in-window flag rises. The fetcher uses it to launch the line read. In interlaced scan each field walks every second source line, and the bottom field starts one pitch further into memory.

A small state machine follows the vertical position within a frame. ST_EMPTY is held while the window is empty. ST_EMPTY goes to ST_ABOVE once the window becomes valid. ST_ABOVE waits for the first window line, and its first request goes to ST_INSIDE and loads the base address. ST_INSIDE advances the address by one step on every request. ST_INSIDE goes to ST_BELOW when the line counter passes the window end. A drop in the line counter marks a new frame or field, and from ST_INSIDE or ST_BELOW this goes back to ST_ABOVE. An empty window sends any state to ST_EMPTY.

Top module: `plane_viewport_gen`

## Requirements
- R1: While reset is held, `in_win` and `line_req` are 0 and `line_addr` is 0.
- R2: The window start word has the start line in bits [31:16] and the start pixel in bits [15:0]. The window end word packs the end corner the same way, and both corners are inclusive. `in_win` is 1 exactly two clocks after a sampled pixel/line pair that lies inside the window.
- R3: The source size word holds the height in bits [31:16] and the width in bits [15:0]. When the requested window is wider or taller than the source, the effective end becomes start + size − 1 on that axis.
- R4: When the requested window is narrower or shorter than the source, the requested end is kept, and the source is cropped.
- R5: The source width is limited to 3840 and the height to 2160 before the comparison of R3.
- R6: A window whose end lies before its start on either axis, or whose source width or height is 0, produces no `in_win` and no `line_req`, and `line_addr` keeps its value.
- R7: `line_req` is 1 for one clock, one clock after the sample in which the pixel counter equals the start pixel on a window line. This is one clock before `in_win` rises for that line.
- R8: The first request of a progressive frame, or of a top field (`field_bot` = 0), carries the first-pixel address `src_addr`.
- R9: In progressive scan (`interlace` = 0) each later request of the frame carries the previous address plus `src_pitch`. Between requests `line_addr` does not change.
- R10: In interlaced scan (`interlace` = 1) the first request of a bottom field (`field_bot` = 1, sampled at that request) carries `src_addr + src_pitch`. Each later request in the field adds twice `src_pitch`.
- R11: A line counter value lower than in the previous clock starts a new frame or field. The next request reloads the base address, even when it falls in that same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_x | input | 16 | Current pixel counter from timing |
| line_y | input | 16 | Current line counter (field line in interlaced scan) |
| field_bot | input | 1 | 1 while the bottom field is scanned |
| interlace | input | 1 | 1 selects interlaced scan |
| win_start | input | 32 | Window start corner, line [31:16], pixel [15:0] |
| win_end | input | 32 | Inclusive window end corner, line [31:16], pixel [15:0] |
| src_addr | input | 32 | Byte address of the first visible source pixel |
| src_pitch | input | 32 | Source line pitch in bytes |
| src_size | input | 32 | Source height [31:16], width [15:0] |
| in_win | output | 1 | Current position (two clocks back) is inside the window |
| line_req | output | 1 | One-clock line fetch request |
| line_addr | output | 32 | Start address of the requested line |

## Verification
A wrong state in the line tracker shows up on `line_addr` at the very next request strobe. A missed new-frame reload repeats or continues the previous frame's addresses. A stale step shows up from the second window line onwards. Errors in the clamp or in the window comparison show at the ports within two clocks, as an `in_win` edge in the wrong column or on the wrong line, or as a strobe that is missing or misplaced. The bench therefore compares all three outputs on every clock against a behavioural model, so a divergence is reported in the cycle in which it first appears.

// File: rtl/pvg_pkg.sv
package pvg_pkg;

    // Vertical tracking state of the line address generator
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_ABOVE  = 2'd1,
        ST_INSIDE = 2'd2,
        ST_BELOW  = 2'd3
    } pvg_state_e;

    localparam int PVG_AXES = 2;

endpackage

// File: rtl/pvg_axis_clamp.sv
module pvg_axis_clamp #(
    parameter int CW   = 16,
    parameter int MAXN = 3840
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] start,
    input  logic [CW-1:0] end_req,
    input  logic [CW-1:0] src_n,
    output logic          ok,
    output logic [CW:0]   end_eff
);

    localparam logic [CW-1:0] MAXN_V = CW'(MAXN);
    localparam logic [CW:0]   ONE    = (CW+1)'(1);

    logic [CW-1:0] n_lim;
    logic [CW:0]   len_req;
    logic [CW:0]   start_w;

    always_comb begin
        start_w = {1'b0, start};
        n_lim   = (src_n > MAXN_V) ? MAXN_V : src_n;
        ok      = (end_req >= start) && (n_lim != '0);
        len_req = {1'b0, end_req} - start_w + ONE;
        if (len_req > {1'b0, n_lim}) begin
            end_eff = start_w + {1'b0, n_lim} - ONE;
        end else begin
            end_eff = {1'b0, end_req};
        end
    end

    AST_END_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (end_eff >= start_w) && (end_eff <= {1'b0, end_req})); // R4
    AST_LEN_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> ((end_eff - start_w) < {1'b0, MAXN_V})); // R5

endmodule

// File: rtl/pvg_window_hit.sv
module pvg_window_hit #(
    parameter int CW = 16
) (
    input  logic          win_ok,
    input  logic [CW-1:0] pix_x,
    input  logic [CW-1:0] line_y,
    input  logic [CW-1:0] x_start,
    input  logic [CW:0]   x_end,
    input  logic [CW-1:0] y_start,
    input  logic [CW:0]   y_end,
    output logic          row_in,
    output logic          hit,
    output logic          req_evt
);

    logic col_in;

    always_comb begin
        col_in  = (pix_x >= x_start) && ({1'b0, pix_x} <= x_end);
        row_in  = (line_y >= y_start) && ({1'b0, line_y} <= y_end);
        hit     = win_ok && col_in && row_in;
        req_evt = win_ok && row_in && (pix_x == x_start);
    end

endmodule

// File: rtl/pvg_line_addr_fsm.sv
module pvg_line_addr_fsm
    import pvg_pkg::*;
#(
    parameter int CW = 16,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_ok,
    input  logic          req_evt,
    input  logic [CW-1:0] line_y,
    input  logic [CW:0]   y_end,
    input  logic          field_bot,
    input  logic          interlace,
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] pitch,
    output logic          line_req,
    output logic [AW-1:0] line_addr
);

    pvg_state_e    state_q, state_d;
    logic [CW-1:0] last_line_q;
    logic          new_frame;
    logic          first_sel;
    logic [AW-1:0] field_base;
    logic [AW-1:0] step;

    always_comb begin
        new_frame  = line_y < last_line_q;
        first_sel  = new_frame || (state_q == ST_ABOVE) || (state_q == ST_EMPTY);
        field_base = base_addr + ((interlace && field_bot) ? pitch : '0);
        step       = interlace ? {pitch[AW-2:0], 1'b0} : pitch;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!win_ok) begin
            state_d = ST_EMPTY;
        end else if (req_evt) begin
            state_d = ST_INSIDE;
        end else begin
            unique case (state_q)
                ST_EMPTY:  state_d = ST_ABOVE;
                ST_ABOVE:  state_d = ST_ABOVE;
                ST_INSIDE: begin
                    if (new_frame) begin
                        state_d = ST_ABOVE;
                    end else if ({1'b0, line_y} > y_end) begin
                        state_d = ST_BELOW;
                    end
                end
                ST_BELOW: begin
                    if (new_frame) begin
                        state_d = ST_ABOVE;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ABOVE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_req    <= 1'b0;
            line_addr   <= '0;
            last_line_q <= '0;
        end else begin
            line_req    <= req_evt;
            last_line_q <= line_y;
            if (req_evt) begin
                line_addr <= first_sel ? field_base : (line_addr + step);
            end
        end
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_evt |=> $stable(line_addr)); // R9
    AST_REQ_IN_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        line_req |-> (state_q == ST_INSIDE)); // R7
    AST_BELOW_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BELOW && !new_frame) |-> !req_evt); // R11

endmodule

// File: rtl/plane_viewport_gen.sv
module plane_viewport_gen
    import pvg_pkg::*;
#(
    parameter int CW    = 16,
    parameter int AW    = 32,
    parameter int MAX_W = 3840,
    parameter int MAX_H = 2160
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   pix_x,
    input  logic [CW-1:0]   line_y,
    input  logic            field_bot,
    input  logic            interlace,
    input  logic [2*CW-1:0] win_start,
    input  logic [2*CW-1:0] win_end,
    input  logic [AW-1:0]   src_addr,
    input  logic [AW-1:0]   src_pitch,
    input  logic [2*CW-1:0] src_size,
    output logic            in_win,
    output logic            line_req,
    output logic [AW-1:0]   line_addr
);

    // axis 0 = pixel (low half), axis 1 = line (high half)
    logic [CW-1:0] ax_start [PVG_AXES];
    logic [CW-1:0] ax_end   [PVG_AXES];
    logic [CW-1:0] ax_size  [PVG_AXES];
    logic [CW:0]   ax_eff   [PVG_AXES];
    logic          ax_ok    [PVG_AXES];

    logic win_ok;
    logic row_in;
    logic hit;
    logic req_evt;
    logic hit_q;

    for (genvar g = 0; g < PVG_AXES; g++) begin : g_axis
        assign ax_start[g] = win_start[g*CW +: CW];
        assign ax_end[g]   = win_end[g*CW +: CW];
        assign ax_size[g]  = src_size[g*CW +: CW];
        pvg_axis_clamp #(
            .CW   (CW),
            .MAXN ((g == 0) ? MAX_W : MAX_H)
        ) u_clamp (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (ax_start[g]),
            .end_req (ax_end[g]),
            .src_n   (ax_size[g]),
            .ok      (ax_ok[g]),
            .end_eff (ax_eff[g])
        );
    end

    assign win_ok = ax_ok[0] && ax_ok[1];

    pvg_window_hit #(.CW(CW)) u_hit (
        .win_ok  (win_ok),
        .pix_x   (pix_x),
        .line_y  (line_y),
        .x_start (ax_start[0]),
        .x_end   (ax_eff[0]),
        .y_start (ax_start[1]),
        .y_end   (ax_eff[1]),
        .row_in  (row_in),
        .hit     (hit),
        .req_evt (req_evt)
    );

    pvg_line_addr_fsm #(.CW(CW), .AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_ok    (win_ok),
        .req_evt   (req_evt),
        .line_y    (line_y),
        .y_end     (ax_eff[1]),
        .field_bot (field_bot),
        .interlace (interlace),
        .base_addr (src_addr),
        .pitch     (src_pitch),
        .line_req  (line_req),
        .line_addr (line_addr)
    );

    // two-stage window flag so the strobe leads it by one clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            in_win <= 1'b0;
        end else begin
            hit_q  <= hit;
            in_win <= hit_q;
        end
    end

    AST_REQ_LEADS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        line_req |=> in_win); // R7
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !win_ok |=> !line_req); // R6
    AST_ROW_FOR_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_evt |-> row_in); // R2

endmodule

// File: tb/plane_viewport_gen_bench.sv
module plane_viewport_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pix_x = '0;
    logic [15:0] line_y = '0;
    logic        field_bot = 1'b0;
    logic        interlace = 1'b0;
    logic [31:0] win_start = '0;
    logic [31:0] win_end = '0;
    logic [31:0] src_addr = '0;
    logic [31:0] src_pitch = '0;
    logic [31:0] src_size = '0;
    logic        in_win;
    logic        line_req;
    logic [31:0] line_addr;

    always #4 clk = ~clk;

    plane_viewport_gen u_plane_viewport_gen (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .line_y(line_y),
        .field_bot(field_bot), .interlace(interlace), .win_start(win_start),
        .win_end(win_end), .src_addr(src_addr), .src_pitch(src_pitch),
        .src_size(src_size), .in_win(in_win), .line_req(line_req),
        .line_addr(line_addr)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string tag = "";

    // behavioural model state
    longint m_addr;
    bit     m_first;
    int     m_last;
    bit     e_win_p, e_win_pp, e_req_p;
    longint e_addr_p;

    task automatic chk(input string rq, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", rq, tag, act, exp, $time);
        end
    endtask

    function automatic void win_calc(output bit ok, output int xs, output int xe,
                                     output int ys, output int ye);
        int nx, ny, exr, eyr;
        xs = int'(win_start[15:0]); ys = int'(win_start[31:16]);
        exr = int'(win_end[15:0]); eyr = int'(win_end[31:16]);
        nx = int'(src_size[15:0]); ny = int'(src_size[31:16]);
        if (nx > 3840) nx = 3840;
        if (ny > 2160) ny = 2160;
        ok = (exr >= xs) && (eyr >= ys) && nx > 0 && ny > 0;
        xe = (exr - xs + 1 > nx) ? xs + nx - 1 : exr;
        ye = (eyr - ys + 1 > ny) ? ys + ny - 1 : eyr;
    endfunction

    // advance the model with the inputs the design samples at the next edge
    task automatic model_apply();
        bit ok, hit, evt, newf;
        int xs, xe, ys, ye, x, y;
        longint base, stp;
        win_calc(ok, xs, xe, ys, ye);
        x = int'(pix_x); y = int'(line_y);
        hit = ok && x >= xs && x <= xe && y >= ys && y <= ye;
        evt = ok && y >= ys && y <= ye && x == xs;
        newf = y < m_last;
        base = (longint'(src_addr) + ((interlace && field_bot) ? longint'(src_pitch) : 0)) & 64'hFFFF_FFFF;
        stp = interlace ? 2 * longint'(src_pitch) : longint'(src_pitch);
        if (!ok) m_first = 1;
        else if (evt) begin
            m_addr = (m_first || newf) ? base : ((m_addr + stp) & 64'hFFFF_FFFF);
            m_first = 0;
        end else if (newf) m_first = 1;
        m_last = y;
        e_win_pp = e_win_p;
        e_win_p = hit;
        e_req_p = evt;
        e_addr_p = m_addr;
    endtask

    task automatic step(input int x, input int y, input bit fb);
        @(negedge clk);
        chk("R2 in_win", in_win, e_win_pp);
        chk("R7 line_req", line_req, e_req_p);
        chk("R9 line_addr", line_addr, e_addr_p);
        pix_x = 16'(x); line_y = 16'(y); field_bot = fb;
        model_apply();
    endtask

    task automatic do_reset(input bit il, input int xs, input int ys, input int xe, input int ye,
                            input int w, input int h, input longint a, input longint p);
        rst_n = 0;
        interlace = il;
        pix_x = '0; line_y = '0; field_bot = 0;
        win_start = {16'(ys), 16'(xs)};
        win_end = {16'(ye), 16'(xe)};
        src_size = {16'(h), 16'(w)};
        src_addr = 32'(a); src_pitch = 32'(p);
        repeat (3) @(negedge clk);
        chk("R1 in_win reset", in_win, 0);
        chk("R1 line_req reset", line_req, 0);
        chk("R1 line_addr reset", line_addr, 0);
        rst_n = 1;
        m_addr = 0; m_first = 1; m_last = 0;
        e_win_p = 0; e_win_pp = 0; e_req_p = 0; e_addr_p = 0;
        model_apply();
    endtask

    task automatic run_frame(input int hw, input int vh, input bit fb);
        for (int y = 0; y < vh; y++)
            for (int x = 0; x < hw; x++)
                step(x, y, fb);
    endtask

    initial begin
        // R2 R4 R8 R9 R11: progressive crop, two frames
        tag = "R4 crop progressive";
        do_reset(0, 3, 2, 8, 5, 10, 10, 64'h4000, 64'h100);
        run_frame(16, 10, 0);
        tag = "R11 second frame";
        run_frame(16, 10, 0);
        // R3: window larger than source
        tag = "R3 clamp to source";
        do_reset(0, 3, 1, 12, 8, 4, 3, 64'h8000_0000, 64'h40);
        run_frame(16, 10, 0);
        // R10: interlaced top then bottom field
        tag = "R10 interlaced fields";
        do_reset(1, 2, 1, 6, 4, 20, 20, 64'h1000, 64'h200);
        run_frame(12, 6, 0);
        run_frame(12, 6, 1);
        run_frame(12, 6, 0);
        // R7 R11: window at origin, request coincides with new frame
        tag = "R11 origin window";
        do_reset(0, 0, 0, 4, 2, 8, 8, 64'hFFFF_FF00, 64'h80);
        run_frame(8, 5, 0);
        run_frame(8, 5, 0);
        // R6: end before start, and zero source size
        tag = "R6 empty reversed";
        do_reset(0, 5, 3, 2, 6, 8, 8, 64'h2000, 64'h10);
        run_frame(10, 8, 0);
        tag = "R6 empty zero size";
        do_reset(0, 1, 1, 4, 4, 0, 8, 64'h2000, 64'h10);
        run_frame(10, 8, 0);
        // R5: width cap
        tag = "R5 width cap";
        do_reset(0, 100, 0, 4000, 2, 16'hFFFF, 16'hFFFF, 64'h0, 64'h3C00);
        run_frame(4100, 4, 0);
        // R5: height cap
        tag = "R5 height cap";
        do_reset(0, 0, 0, 1, 2200, 2, 16'hFFFF, 64'h100, 64'h8);
        run_frame(4, 2210, 0);
        @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule